// File: doc/BRIEF.md
# Paged Address Translator with Page-Status Tracking

This block maps CPU logical addresses that fall in the low 4 MB of a 24-bit address space onto physical addresses. It keeps a table of 1024 page descriptors, each 16 bits wide, in internal registers. Each logical address splits into a 10-bit page index and a 12-bit in-page offset. The descriptor that the index selects supplies a 10-bit physical page number. The physical address is that page number followed by the unchanged offset. Addresses at or above 0x400000 are not translated and pass straight through.

Every strobed access to a low-region page also updates a 2-bit usage field in that page's descriptor. This lets software see which pages have been touched and which have been modified. A CPU-side port writes descriptors one byte lane at a time and reads them back whole. Permission checks and fault signalling belong to other logic. This block never refuses or flags an access.

Top module: `pgx_translator`

## Requirements
- R1: An address with either of bits 23:22 set appears unchanged on the physical output. An access strobe on such an address modifies no descriptor.
- R2: For an address below 0x400000, the physical output equals {2'b00, descriptor[9:0], address[11:0]}, where the descriptor is selected by address bits 21:12. The output is combinational from the stored table and the current address.
- R3: The usage field is descriptor bits 14:13, with these codes: 0 = absent, 1 = present and untouched, 2 = referenced by a read, 3 = dirty.
- R4: A strobed read of a page with code 1 sets its code to 2 at the next clock edge.
- R5: A strobed write of a page with code 1 sets its code to 3 at the next clock edge.
- R6: A strobed write of a page with code 2 or 3 leaves code 3. A strobed read of a page with code 2 or 3 keeps the code unchanged.
- R7: A strobed access of a page with code 0 still translates, but it leaves the descriptor unchanged.
- R8: Descriptor bit 15 and bits 12:10 are stored and read back exactly as written. No status update alters them.
- R9: The CPU port writes descriptor bits 15:8 when select bit 1 is high and bits 7:0 when select bit 0 is high. The read port returns the whole descriptor chosen by the CPU index, combinationally. After reset, every descriptor is 0.
- R10: A CPU write in the same cycle as a strobed access to the same descriptor takes priority, whichever bytes it enables. The descriptor then holds exactly the CPU data in the enabled bytes, and no status update is applied to it in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuWrEn | input | 1 | Descriptor write strobe |
| cpuSel | input | 2 | Byte-lane enables: bit 1 is the high byte, bit 0 is the low byte |
| cpuIdx | input | 10 | Descriptor index for CPU read and write |
| cpuWrData | input | 16 | Descriptor write data |
| cpuRdData | output | 16 | Descriptor at cpuIdx |
| xlatValid | input | 1 | Access strobe; enables the status update |
| xlatWrite | input | 1 | Access is a write |
| xlatAddr | input | 24 | Logical address |
| xlatPhys | output | 24 | Physical address |

## Verification
A wrong usage code shows up one clock edge after the faulty access, on the descriptor read port, and it stays there until software rewrites the entry. Checks therefore read back each descriptor right after every access that could have changed it. A corrupted page number appears on the physical output in the same cycle as the next access to that page. Pass-through and same-cycle collisions are checked by reading back a descriptor that shares the page index, to show that nothing was written to it.

// File: rtl/pgx_pkg.sv
package pgx_pkg;
  localparam int ADDR_W   = 24;
  localparam int OFF_W    = 12;
  localparam int IDX_W    = 10;
  localparam int ENTRY_W  = 16;
  localparam int PPN_W    = 10;
  localparam int ST_LSB   = 13;
  localparam int DEPTH    = 1 << IDX_W;

  typedef enum logic [1:0] {
    ST_ABSENT = 2'd0,
    ST_FRESH  = 2'd1,
    ST_REF    = 2'd2,
    ST_DIRTY  = 2'd3
  } pageState_e;

  typedef struct packed {
    logic       stWe;
    pageState_e stNew;
  } pgxStrobe_t;
endpackage

// File: rtl/pgx_ctrl.sv
module pgx_ctrl
  import pgx_pkg::*;
(
  input  logic       xlatValid,
  input  logic       xlatWrite,
  input  logic       inRange,
  input  logic       cpuHit,
  input  pageState_e curState,
  output pgxStrobe_t strobe
);
  pageState_e nextState;

  always_comb begin
    nextState = curState;
    unique case (curState)
      ST_ABSENT: nextState = ST_ABSENT;
      ST_FRESH:  nextState = xlatWrite ? ST_DIRTY : ST_REF;
      ST_REF:    nextState = xlatWrite ? ST_DIRTY : ST_REF;
      ST_DIRTY:  nextState = ST_DIRTY;
      default:   nextState = curState;
    endcase
  end

  always_comb begin
    strobe.stNew = nextState;
    strobe.stWe  = xlatValid && inRange && !cpuHit && (nextState != curState);
  end
endmodule

// File: rtl/pgx_datapath.sv
module pgx_datapath
  import pgx_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               cpuWrEn,
  input  logic [1:0]         cpuSel,
  input  logic [IDX_W-1:0]   cpuIdx,
  input  logic [ENTRY_W-1:0] cpuWrData,
  output logic [ENTRY_W-1:0] cpuRdData,
  input  logic               xlatValid,
  input  logic               xlatWrite,
  input  logic [ADDR_W-1:0]  xlatAddr,
  output logic [ADDR_W-1:0]  xlatPhys,
  input  pgxStrobe_t         strobe,
  output logic               inRange,
  output logic               cpuHit,
  output pageState_e         curState
);
  localparam int HI_W = ADDR_W - OFF_W - IDX_W;
  localparam int PAD_W = ADDR_W - OFF_W - PPN_W;

  logic [ENTRY_W-1:0] mapMem [DEPTH];
  logic [IDX_W-1:0]   pageIdx;
  logic [ENTRY_W-1:0] curEntry;

  assign pageIdx   = xlatAddr[OFF_W +: IDX_W];
  assign inRange   = (xlatAddr[ADDR_W-1 -: HI_W] == '0);
  assign curEntry  = mapMem[pageIdx];
  assign curState  = pageState_e'(curEntry[ST_LSB +: 2]);
  assign cpuHit    = cpuWrEn && (cpuSel != 2'b00) && (cpuIdx == pageIdx);
  assign cpuRdData = mapMem[cpuIdx];

  always_comb begin
    if (inRange) xlatPhys = {{PAD_W{1'b0}}, curEntry[PPN_W-1:0], xlatAddr[OFF_W-1:0]};
    else         xlatPhys = xlatAddr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mapMem[i] <= '0;
    end else begin
      if (strobe.stWe) mapMem[pageIdx][ST_LSB +: 2] <= strobe.stNew;
      if (cpuWrEn) begin
        if (cpuSel[1]) mapMem[cpuIdx][ENTRY_W-1:8] <= cpuWrData[ENTRY_W-1:8];
        if (cpuSel[0]) mapMem[cpuIdx][7:0]         <= cpuWrData[7:0];
      end
    end
  end

  // R1: no status write is requested outside the translated region
  assert_no_upper_update_R1: assert property (@(posedge clk) disable iff (!rstN)
    strobe.stWe |-> inRange);

  // R4: a read of an untouched page leaves it marked referenced
  assert_read_ref_R4: assert property (@(posedge clk) disable iff (!rstN)
    (xlatValid && inRange && !xlatWrite && curState == ST_FRESH && !cpuWrEn)
    |=> mapMem[$past(pageIdx)][ST_LSB +: 2] == 2'd2);

  // R5: a write to any present page leaves it dirty
  assert_write_dirty_R5: assert property (@(posedge clk) disable iff (!rstN)
    (xlatValid && inRange && xlatWrite && curState != ST_ABSENT && !cpuWrEn)
    |=> mapMem[$past(pageIdx)][ST_LSB +: 2] == 2'd3);

  // R7: an absent page's descriptor does not move on access
  assert_absent_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (xlatValid && inRange && curState == ST_ABSENT && !cpuWrEn)
    |=> mapMem[$past(pageIdx)] == $past(curEntry));

  // R10: the enabled high byte of a CPU write lands intact
  assert_cpu_wins_R10: assert property (@(posedge clk) disable iff (!rstN)
    (cpuWrEn && cpuSel[1])
    |=> mapMem[$past(cpuIdx)][ENTRY_W-1:8] == $past(cpuWrData[ENTRY_W-1:8]));
endmodule

// File: rtl/pgx_translator.sv
module pgx_translator
  import pgx_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               cpuWrEn,
  input  logic [1:0]         cpuSel,
  input  logic [IDX_W-1:0]   cpuIdx,
  input  logic [ENTRY_W-1:0] cpuWrData,
  output logic [ENTRY_W-1:0] cpuRdData,
  input  logic               xlatValid,
  input  logic               xlatWrite,
  input  logic [ADDR_W-1:0]  xlatAddr,
  output logic [ADDR_W-1:0]  xlatPhys
);
  pgxStrobe_t strobe;
  logic       inRange;
  logic       cpuHit;
  pageState_e curState;

  pgx_ctrl u_ctrl (
    .xlatValid (xlatValid),
    .xlatWrite (xlatWrite),
    .inRange   (inRange),
    .cpuHit    (cpuHit),
    .curState  (curState),
    .strobe    (strobe)
  );

  pgx_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .cpuWrEn   (cpuWrEn),
    .cpuSel    (cpuSel),
    .cpuIdx    (cpuIdx),
    .cpuWrData (cpuWrData),
    .cpuRdData (cpuRdData),
    .xlatValid (xlatValid),
    .xlatWrite (xlatWrite),
    .xlatAddr  (xlatAddr),
    .xlatPhys  (xlatPhys),
    .strobe    (strobe),
    .inRange   (inRange),
    .cpuHit    (cpuHit),
    .curState  (curState)
  );
endmodule

// File: tb/sim_pgx_translator.sv
`timescale 1ns/1ps
module sim_pgx_translator;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cpuWrEn = 1'b0;
  logic [1:0]  cpuSel = 2'b00;
  logic [9:0]  cpuIdx = '0;
  logic [15:0] cpuWrData = '0;
  logic [15:0] cpuRdData;
  logic        xlatValid = 1'b0;
  logic        xlatWrite = 1'b0;
  logic [23:0] xlatAddr = '0;
  logic [23:0] xlatPhys;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [15:0] mdl [1024];
  int    kindQ[$];
  int    expQ[$];
  string tagQ[$];

  always #2 clk = ~clk;

  pgx_translator u0 (.*);

  function automatic logic [23:0] predictPhys(logic [23:0] a);
    if (a[23:22] != 2'b00) return a;
    return {2'b00, mdl[a[21:12]][9:0], a[11:0]};
  endfunction

  function automatic void modelAccess(logic [23:0] a, logic w);
    logic [1:0] s;
    if (a[23:22] != 2'b00) return;
    s = mdl[a[21:12]][14:13];
    if (s == 2'd1) mdl[a[21:12]][14:13] = w ? 2'd3 : 2'd2;
    else if (s != 2'd0 && w) mdl[a[21:12]][14:13] = 2'd3;
  endfunction

  function automatic void modelCpu(logic [9:0] i, logic [15:0] d, logic [1:0] sel);
    if (sel[1]) mdl[i][15:8] = d[15:8];
    if (sel[0]) mdl[i][7:0]  = d[7:0];
  endfunction

  task automatic idle();
    cpuWrEn = 1'b0; cpuSel = 2'b00; xlatValid = 1'b0; xlatWrite = 1'b0;
  endtask

  task automatic wrEntry(logic [9:0] i, logic [15:0] d, logic [1:0] sel);
    @(negedge clk);
    idle();
    cpuWrEn = 1'b1; cpuSel = sel; cpuIdx = i; cpuWrData = d;
    modelCpu(i, d, sel);
  endtask

  task automatic access(logic [23:0] a, logic w, string tag);
    @(negedge clk);
    idle();
    xlatValid = 1'b1; xlatWrite = w; xlatAddr = a;
    kindQ.push_back(0); expQ.push_back(int'(predictPhys(a))); tagQ.push_back(tag);
    modelAccess(a, w);
  endtask

  task automatic chkEntry(logic [9:0] i, string tag);
    @(negedge clk);
    idle();
    cpuIdx = i;
    kindQ.push_back(1); expQ.push_back(int'(mdl[i])); tagQ.push_back(tag);
  endtask

  task automatic collide(logic [15:0] d, logic [1:0] sel, logic [23:0] a, logic w, string tag);
    @(negedge clk);
    idle();
    xlatValid = 1'b1; xlatWrite = w; xlatAddr = a;
    cpuWrEn = 1'b1; cpuSel = sel; cpuIdx = a[21:12]; cpuWrData = d;
    kindQ.push_back(0); expQ.push_back(int'(predictPhys(a))); tagQ.push_back(tag);
    modelCpu(a[21:12], d, sel);
  endtask

  // monitor: compares queued expectations one time unit after the driving edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (kindQ.size() > 0) begin
        int k; int e; string t; int act;
        k = kindQ.pop_front(); e = expQ.pop_front(); t = tagQ.pop_front();
        act = (k == 0) ? int'(xlatPhys) : int'(cpuRdData);
        checks++;
        if (act != e) begin
          errors++;
          $display("FAIL %s: %s actual 0x%06h expected 0x%06h", t,
                   (k == 0) ? "phys" : "entry", act, e);
        end
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 1024; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    chkEntry(10'h005, "R9 reset entry zero");
    access(24'h003123, 1'b1, "R2 R7 translate absent page after reset");
    chkEntry(10'h003, "R7 absent page unchanged");

    wrEntry(10'h0AB, 16'h2155, 2'b11);
    wrEntry(10'h0AC, 16'hA001, 2'b11);
    wrEntry(10'h0AD, 16'h0033, 2'b11);
    wrEntry(10'h012, 16'h2055, 2'b11);
    wrEntry(10'h0AE, 16'h2200, 2'b11);
    wrEntry(10'h0AF, 16'h3C07, 2'b11);

    access(24'h0AB456, 1'b0, "R2 translate read");
    chkEntry(10'h0AB, "R4 fresh read becomes referenced");
    access(24'h0AB000, 1'b0, "R2 translate offset zero");
    chkEntry(10'h0AB, "R6 referenced read unchanged");
    access(24'h0ABFFF, 1'b1, "R2 translate offset max");
    chkEntry(10'h0AB, "R6 referenced write becomes dirty");
    access(24'h0AB800, 1'b0, "R3 dirty page translate");
    chkEntry(10'h0AB, "R6 dirty read unchanged");

    access(24'h0AC010, 1'b1, "R5 translate write");
    chkEntry(10'h0AC, "R5 R8 fresh write dirty, bit15 kept");
    access(24'h0AF3FF, 1'b0, "R2 high page number");
    chkEntry(10'h0AF, "R8 bits 12:10 kept");

    access(24'h0AD777, 1'b1, "R7 translate absent write");
    chkEntry(10'h0AD, "R7 absent write no update");

    access(24'h812345, 1'b1, "R1 pass through");
    chkEntry(10'h012, "R1 aliased entry untouched");
    access(24'h4AB456, 1'b1, "R1 pass through low alias");
    chkEntry(10'h0AB, "R1 aliased entry untouched");

    wrEntry(10'h0AB, 16'h0077, 2'b01);
    chkEntry(10'h0AB, "R9 low byte only");
    wrEntry(10'h0AD, 16'h40FF, 2'b10);
    chkEntry(10'h0AD, "R9 high byte only");

    collide(16'h2000, 2'b10, 24'h0AE123, 1'b0, "R10 translate during collision");
    chkEntry(10'h0AE, "R10 cpu high byte wins");
    collide(16'h0099, 2'b01, 24'h0AE456, 1'b1, "R10 translate during low collision");
    chkEntry(10'h0AE, "R10 low byte write suppresses status update");
    access(24'h0AE000, 1'b1, "R10 follow-up access");
    chkEntry(10'h0AE, "R5 update after collision");

    @(negedge clk);
    idle();
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule